// File: doc/BRIEF.md
# SDRAM Command Mode Engine

This block sends SDRAM commands to up to two chip-select banks. Software writes one 32-bit command word. The low three bits pick the operation. Two bits pick which banks receive it. A four-bit field sets how many times an auto-refresh repeats. A field higher up carries a mode-register value. The engine drives the chip selects, RAS_n, CAS_n, WE_n, CKE and the address pins. It holds a busy bit in its status word until the sequence has finished, so software polls that bit before it writes the next command. A second write port loads a refresh period. Once the engine has been put into normal operation, it issues one auto-refresh to the banks named by that normal command each time the period runs out.

The engine is a four-state machine:
- S_IDLE: waits for work.
- S_ISSUE: drives one command cycle.
- S_GAP: holds the pins at no-operation between repeated auto-refresh cycles.
- S_TREF: drives a timer refresh.

The transitions are:
- S_IDLE to S_ISSUE on an accepted write.
- S_IDLE to S_TREF when a refresh is due and no write is accepted in that cycle.
- S_ISSUE to S_GAP when auto-refresh repeats remain.
- S_ISSUE to S_IDLE otherwise.
- S_GAP to S_ISSUE when the spacing count runs out.
- S_TREF to S_IDLE after one cycle.

Busy is high in every state except S_IDLE.

Top module: `sdcmd_engine`

## Requirements
- R1: The command code is `cmd_word[2:0]`. A valid write sampled in S_IDLE sets `stat_o[5]` (busy) from the next cycle. Busy returns to 0 when the sequence ends. A code other than auto-refresh keeps busy high for exactly one cycle. Codes: 0 normal, 1 clock enable, 2 precharge all, 3 auto-refresh, 4 load mode, 5 self-refresh, 6 power-down.
- R2: `cmd_word[4]` selects bank 1, driven on `cs_n_o[0]`. `cmd_word[3]` selects bank 2, driven on `cs_n_o[1]`. Either bank or both may be selected. Chip selects go low only while busy.
- R3: Precharge all drives RAS_n=0, CAS_n=1 and WE_n=0 with `addr_o[10]`=1, for one cycle.
- R4: Auto-refresh drives RAS_n=0, CAS_n=0, WE_n=1 with CKE high. It is issued `cmd_word[8:5]`+1 times.
- R5: Between two auto-refresh cycles of one command, the pins show no-operation for max(`trc_cycles`,1) cycles. Busy therefore lasts n + (n-1)*max(trc,1) cycles for n refreshes.
- R6: Load mode drives RAS_n, CAS_n and WE_n all low. `addr_o` carries `cmd_word[9+ADDR_W-1:9]`.
- R7: Some writes are ignored: busy stays low and no command reaches the pins. This applies to code 7, to a write with bits 4 and 3 both clear, and to any write made while busy.
- R8: CKE is low after reset. Code 1 raises it. Codes 5 and 6 drop it. Self-refresh drives the refresh pin pattern with CKE already low. Power-down leaves the chip selects high.
- R9: The refresh period is `rfsh_word[RT_W:1]`, loaded by `rfsh_wr`. After reset the period is 8196. After code 0, the engine issues one auto-refresh to the banks named in that normal command every period+1 cycles.
- R10: A refresh that comes due while a command is in progress waits. It is issued after that command's last cycle, and it is not lost.
- R11: Codes 5 and 6 stop the refresh timer and drop any pending refresh. No timer refresh occurs until a new normal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| rfsh_wr | input | 1 | Refresh period write strobe |
| rfsh_word | input | 32 | Refresh period word, period in bits RT_W:1 |
| trc_cycles | input | TRC_W | Spacing between repeated auto-refresh cycles |
| stat_o | output | 8 | Status word, bit 5 busy |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 2 | Chip selects, index 0 bank 1, index 1 bank 2 |
| ras_n_o | output | 1 | Row strobe |
| cas_n_o | output | 1 | Column strobe |
| we_n_o | output | 1 | Write enable |
| addr_o | output | ADDR_W | SDRAM address pins |

## Verification
The bench counts the cycles of a repeated auto-refresh with a spacing of 3 and with a spacing of 0. A design that drops one repeat, adds one, or treats a spacing of zero as zero cycles of gap gives a busy length other than 29 or 3.

It checks the bank-to-chip-select mapping, which a design that swaps the two bank bits fails. It also sends writes while the engine is busy. A design that does not block those writes would emit a stray precharge.

For the timer, the bench measures the default period and a programmed period. It then lets a refresh come due during a long software refresh. A design that interleaves the timer refresh shows a both-bank pulse among the bank-1 pulses, and a design that loses it shows no both-bank pulse afterwards. Finally it confirms that no timer refresh appears after self-refresh.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        MC_NORMAL    = 3'd0,
        MC_CKE_ON    = 3'd1,
        MC_PRE_ALL   = 3'd2,
        MC_AUTO_REF  = 3'd3,
        MC_LOAD_MODE = 3'd4,
        MC_SELF_REF  = 3'd5,
        MC_PWR_DN    = 3'd6,
        MC_RSVD      = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_GAP,
        S_TREF
    } state_e;

    typedef struct packed {
        logic [1:0] cs_n;
        logic       ras_n;
        logic       cas_n;
        logic       we_n;
    } pins_t;

    localparam int BANK1_BIT   = 4;
    localparam int BANK2_BIT   = 3;
    localparam int REP_LSB     = 5;
    localparam int REP_W       = 4;
    localparam int PAYLOAD_LSB = 9;
    localparam int BUSY_BIT    = 5;
    localparam int A10_BIT     = 10;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [31:0]       word,
    output mode_e             mode,
    output logic [1:0]        banks,
    output logic [REP_W-1:0]  reps,
    output logic [ADDR_W-1:0] payload,
    output logic              valid
);
    localparam int TOP_USED = PAYLOAD_LSB + ADDR_W;

    logic unused_hi;
    assign unused_hi = ^word[31:TOP_USED];

    always_comb begin
        mode    = mode_e'(word[2:0]);
        banks   = {word[BANK2_BIT], word[BANK1_BIT]};
        reps    = word[REP_LSB +: REP_W];
        payload = word[PAYLOAD_LSB +: ADDR_W];
        valid   = (mode != MC_RSVD) && (banks != 2'b00);
    end
endmodule

// File: rtl/sdcmd_rfsh_timer.sv
module sdcmd_rfsh_timer #(
    parameter int RT_W       = 14,
    parameter int RT_DEFAULT = 8196
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] word,
    input  logic        run,
    input  logic        restart,
    input  logic        ack,
    output logic        due
);
    localparam logic [RT_W-1:0] RESET_VAL = RT_DEFAULT[RT_W-1:0];

    logic [RT_W-1:0] reload_q;
    logic [RT_W-1:0] cnt_q;
    logic            tick;
    logic            unused_lo;

    assign unused_lo = ^{word[31:RT_W+1], word[0]};
    assign tick      = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= RESET_VAL;
            cnt_q    <= RESET_VAL;
            due      <= 1'b0;
        end else begin
            if (load) begin
                reload_q <= word[RT_W:1];
                cnt_q    <= word[RT_W:1];
            end else if (restart) begin
                cnt_q <= reload_q;
            end else if (run) begin
                cnt_q <= tick ? reload_q : cnt_q - 1'b1;
            end
            due <= run && ((due && !ack) || tick);
        end
    end

    // R11: a stopped timer never leaves a refresh pending
    a_r11_no_due_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !due);
endmodule

// File: rtl/sdcmd_pin_drive.sv
module sdcmd_pin_drive
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  state_e            state,
    input  mode_e             mode,
    input  logic [1:0]        banks,
    input  logic [1:0]        ref_mask,
    input  logic [ADDR_W-1:0] payload,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        pins = '{cs_n: 2'b11, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        addr = '0;
        unique case (state)
            S_ISSUE: begin
                unique case (mode)
                    MC_PRE_ALL: begin
                        pins.cs_n     = ~banks;
                        pins.ras_n    = 1'b0;
                        pins.we_n     = 1'b0;
                        addr[A10_BIT] = 1'b1;
                    end
                    MC_AUTO_REF, MC_SELF_REF: begin
                        pins.cs_n  = ~banks;
                        pins.ras_n = 1'b0;
                        pins.cas_n = 1'b0;
                    end
                    MC_LOAD_MODE: begin
                        pins.cs_n  = ~banks;
                        pins.ras_n = 1'b0;
                        pins.cas_n = 1'b0;
                        pins.we_n  = 1'b0;
                        addr       = payload;
                    end
                    default: ;
                endcase
            end
            S_TREF: begin
                pins.cs_n  = ~ref_mask;
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int TRC_W      = 4,
    parameter int RT_W       = 14,
    parameter int RT_DEFAULT = 8196
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_word,
    input  logic              rfsh_wr,
    input  logic [31:0]       rfsh_word,
    input  logic [TRC_W-1:0]  trc_cycles,
    output logic [7:0]        stat_o,
    output logic              cke_o,
    output logic [1:0]        cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o
);
    state_e             state_q, state_d;
    mode_e              dec_mode, cur_mode;
    logic [1:0]         dec_banks, cur_banks, ref_mask;
    logic [REP_W-1:0]   dec_reps, rep_left;
    logic [ADDR_W-1:0]  dec_payload, cur_payload;
    logic               dec_valid;
    logic [TRC_W-1:0]   gap_cnt;
    logic               normal_on, ref_due, acc, take_ref, busy;
    pins_t              pins;

    sdcmd_decode #(.ADDR_W(ADDR_W)) dec_i (
        .word(cmd_word), .mode(dec_mode), .banks(dec_banks),
        .reps(dec_reps), .payload(dec_payload), .valid(dec_valid)
    );

    sdcmd_rfsh_timer #(.RT_W(RT_W), .RT_DEFAULT(RT_DEFAULT)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(rfsh_wr), .word(rfsh_word),
        .run(normal_on), .restart(acc && dec_mode == MC_NORMAL),
        .ack(take_ref), .due(ref_due)
    );

    assign acc      = (state_q == S_IDLE) && cmd_wr && dec_valid;
    assign take_ref = (state_q == S_IDLE) && !acc && ref_due;
    assign busy     = (state_q != S_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (acc)           state_d = S_ISSUE;
                else if (take_ref) state_d = S_TREF;
            end
            S_ISSUE: begin
                if (cur_mode == MC_AUTO_REF && rep_left != '0) state_d = S_GAP;
                else                                             state_d = S_IDLE;
            end
            S_GAP:   if (gap_cnt <= 1) state_d = S_ISSUE;
            S_TREF:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // command context, repeat and spacing counters, CKE and normal mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mode    <= MC_NORMAL;
            cur_banks   <= 2'b00;
            cur_payload <= '0;
            rep_left    <= '0;
            gap_cnt     <= '0;
            cke_o       <= 1'b0;
            normal_on   <= 1'b0;
            ref_mask    <= 2'b00;
        end else begin
            if (acc) begin
                cur_mode    <= dec_mode;
                cur_banks   <= dec_banks;
                cur_payload <= dec_payload;
                rep_left    <= dec_reps;
                unique case (dec_mode)
                    MC_NORMAL: begin
                        normal_on <= 1'b1;
                        ref_mask  <= dec_banks;
                    end
                    MC_CKE_ON: cke_o <= 1'b1;
                    MC_SELF_REF, MC_PWR_DN: begin
                        cke_o     <= 1'b0;
                        normal_on <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (state_q == S_ISSUE && state_d == S_GAP) gap_cnt <= trc_cycles;
            if (state_q == S_GAP) begin
                if (gap_cnt <= 1) rep_left <= rep_left - 1'b1;
                else              gap_cnt  <= gap_cnt - 1'b1;
            end
        end
    end

    // outputs
    sdcmd_pin_drive #(.ADDR_W(ADDR_W)) drv_i (
        .state(state_q), .mode(cur_mode), .banks(cur_banks),
        .ref_mask(ref_mask), .payload(cur_payload), .pins(pins), .addr(addr_o)
    );

    always_comb begin
        stat_o           = '0;
        stat_o[BUSY_BIT] = busy;
        cs_n_o           = pins.cs_n;
        ras_n_o          = pins.ras_n;
        cas_n_o          = pins.cas_n;
        we_n_o           = pins.we_n;
    end

    a_r7_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_wr && cmd_word[2:0] == 3'd7 && !ref_due) |=> !stat_o[BUSY_BIT]);

    a_r7_nobank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_wr && cmd_word[4:3] == 2'b00 && !ref_due) |=> !stat_o[BUSY_BIT]);

    a_r3_pre_a10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && cas_n_o && !we_n_o) |-> addr_o[A10_BIT]);

    a_r8_cke_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> $past(cmd_wr && cmd_word[2:0] == 3'd1));

    a_r2_cs_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_o != 2'b11) |-> stat_o[BUSY_BIT]);

    a_r5_gap_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |-> (cs_n_o == 2'b11 && ras_n_o && cas_n_o && we_n_o));
endmodule

// File: tb/sdcmd_engine_tb_top.sv
module sdcmd_engine_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        rfsh_wr = 1'b0;
    logic [31:0] rfsh_word = '0;
    logic [3:0]  trc_cycles = '0;
    logic [7:0]  stat_o;
    logic        cke_o, ras_n_o, cas_n_o, we_n_o;
    logic [1:0]  cs_n_o;
    logic [12:0] addr_o;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    sdcmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .rfsh_wr(rfsh_wr), .rfsh_word(rfsh_word), .trc_cycles(trc_cycles),
        .stat_o(stat_o), .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic is_ref();
        return cke_o && !ras_n_o && !cas_n_o && we_n_o && cs_n_o != 2'b11;
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_word = w;
        cmd_wr   = 1'b1;
        @(negedge clk);
        cmd_wr   = 1'b0;
        cmd_word = '0;
    endtask

    task automatic wait_ref(output int t);
        t = 0;
        while (!is_ref() && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset busy", 32'(stat_o), 32'h0);
        chk("R8 reset pins", {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o}, 32'b011111);
    endtask

    task automatic t_cke();
        send(32'h11);
        chk("R1 busy set", 32'(stat_o[5]), 1);
        chk("R8 cke raised", 32'(cke_o), 1);
        @(negedge clk);
        chk("R1 one cycle busy", 32'(stat_o[5]), 0);
    endtask

    task automatic t_pre();
        send(32'h1A);
        chk("R3 pins", {ras_n_o, cas_n_o, we_n_o}, 32'b010);
        chk("R3 a10", 32'(addr_o[10]), 1);
        chk("R2 both cs", 32'(cs_n_o), 32'b00);
        @(negedge clk);
        send(32'h12);
        chk("R2 bank1 cs", 32'(cs_n_o), 32'b10);
        @(negedge clk);
        send(32'h0A);
        chk("R2 bank2 cs", 32'(cs_n_o), 32'b01);
        @(negedge clk);
    endtask

    task automatic t_mrs();
        send((32'h230 << 9) | 32'h0C);
        chk("R6 pins", {ras_n_o, cas_n_o, we_n_o}, 32'b000);
        chk("R6 payload", 32'(addr_o), 32'h230);
        chk("R6 cs", 32'(cs_n_o), 32'b01);
        @(negedge clk);
    endtask

    task automatic t_aref(input int f, input int trc, input logic [31:0] bk,
                          input int exp_busy);
        int n = 0;
        int p = 0;
        trc_cycles = 4'(trc);
        send((32'(f) << 5) | bk | 32'h3);
        while (stat_o[5] && n < 500) begin
            if (is_ref()) p++;
            n++;
            @(negedge clk);
        end
        chk("R4 refresh count", 32'(p), 32'(f + 1));
        chk("R5 busy length", 32'(n), 32'(exp_busy));
    endtask

    task automatic t_ignored();
        int pre = 0;
        send(32'h1F);
        chk("R7 reserved busy", 32'(stat_o[5]), 0);
        chk("R7 reserved pins", 32'(cs_n_o), 32'b11);
        send(32'h03);
        chk("R7 no bank busy", 32'(stat_o[5]), 0);
        trc_cycles = 4'd2;
        send(32'h73);
        send(32'h1A);
        for (int i = 0; i < 20; i++) begin
            if (!ras_n_o && cas_n_o && !we_n_o) pre++;
            @(negedge clk);
        end
        chk("R7 write while busy", 32'(pre), 0);
    endtask

    task automatic t_timer_default();
        int a, b;
        send(32'h10);
        wait_ref(a);
        @(negedge clk);
        wait_ref(b);
        chk("R9 default period", 32'(b + 1), 32'd8197);
        chk("R9 refresh banks", 32'(cs_n_o), 32'b10);
    endtask

    task automatic t_timer_prog();
        int a, b;
        @(negedge clk);
        rfsh_word = 32'd5 << 1;
        rfsh_wr   = 1'b1;
        @(negedge clk);
        rfsh_wr   = 1'b0;
        send(32'h18);
        wait_ref(a);
        @(negedge clk);
        wait_ref(b);
        chk("R9 programmed period", 32'(b + 1), 32'd6);
        chk("R9 both banks", 32'(cs_n_o), 32'b00);
    endtask

    task automatic t_defer();
        int t;
        int k = 0;
        logic [1:0] seen [9];
        wait_ref(t);
        trc_cycles = 4'd3;
        send(32'hF3);
        for (int i = 0; i < 80 && k < 9; i++) begin
            if (is_ref()) begin
                seen[k] = cs_n_o;
                k++;
            end
            @(negedge clk);
        end
        chk("R10 pulses seen", 32'(k), 9);
        for (int j = 0; j < 8; j++) chk("R10 sw refresh bank1", 32'(seen[j]), 32'b10);
        chk("R10 deferred timer refresh", 32'(seen[8]), 32'b00);
    endtask

    task automatic t_stop();
        int t;
        int r = 0;
        wait_ref(t);
        send(32'h1D);
        chk("R8 self refresh", {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o}, 32'b000001);
        send(32'h11);
        for (int i = 0; i < 30; i++) begin
            if (is_ref()) r++;
            @(negedge clk);
        end
        chk("R11 timer stopped", 32'(r), 0);
        send(32'h16);
        chk("R8 power down", {cke_o, cs_n_o}, 32'b011);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cke();
        t_pre();
        t_mrs();
        t_aref(7, 3, 32'h10, 29);
        t_aref(1, 0, 32'h18, 3);
        t_aref(0, 5, 32'h08, 1);
        t_ignored();
        t_timer_default();
        t_timer_prog();
        t_defer();
        t_stop();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule